// File: doc/BRIEF.md
# Sync-Triggered Transparent Serial Receiver

This block receives an unframed bit stream, one bit per rising edge of its serial clock, and turns it into fixed-width characters. The characters are grouped into buffers with a length set in characters. Reception does not begin until the receiver has locked onto the line, and it can lock in one of two ways. In pin mode, an active-low sync input is watched until it is first seen low. From that edge on the receiver keeps lock until it is disabled. In slot mode, a frame-sync pulse marks bit position zero of a frame, and only the bits that fall inside a programmable window of that frame are taken.

Each completed character is presented with a one-cycle strobe. When the last character of a buffer arrives, an end-of-buffer pulse comes with it. A separate buffer-filled pulse also comes with it unless the continuous flag is set for that buffer. In that case the same buffer is reused on the next pass. Memory writes, descriptor handling and interrupts are left to the surrounding logic. That logic drives the buffer length and the continuous flag for the buffer in progress.

Top module: `sync_xparent_rx`

## Requirements
- R1: While `rx_en` is high and the receiver is not yet locked in pin mode (`slot_mode`=0), the first rising clock edge that samples `sync_n` low sets `synced`, which is visible after that edge. With `rx_en` low, `sync_n` low has no effect.
- R2: The `rx_bit` value sampled on the edge that achieves pin-mode lock is the first bit (bit 0) of the first character.
- R3: Once locked in pin mode, every following edge takes a bit, `sync_n` is ignored, and `synced` stays high until `rx_en` is low.
- R4: Reset, and any edge with `rx_en` low, clear `synced`, discard a partly assembled character and set the buffer character count back to zero. `char_valid`, `buf_wrap` and `buf_full` are low afterwards.
- R5: In slot mode an edge with `frame_sync` high is frame position 0, and each later edge is one position further on. A bit is taken only at positions `slot_offset` to `slot_offset`+`slot_width`-1, in every frame. No bit is taken before the first frame sync.
- R6: `slot_mode`, `slot_offset` and `slot_width` are captured on the first enabled edge. Changes to them while `rx_en` stays high have no effect.
- R7: Bits are packed least-significant first into CHAR_W-bit characters. `char_valid` is high for one cycle, with `char_data`, in the cycle after the edge that took the last bit.
- R8: `buf_wrap` is high together with `char_valid` for the `buf_len`-th character of each buffer (a value of 0 means 2**LEN_W). The count then restarts at zero and the next bit goes on without a gap.
- R9: `buf_full` is high exactly when `buf_wrap` is high and `buf_cont` was low on the edge that took the buffer's last bit.
- R10: In slot mode `synced` goes high after the edge that takes the first bit of the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low clears lock and partial state |
| slot_mode | input | 1 | 0 = pin sync, 1 = time-slot mode (captured on enable) |
| sync_n | input | 1 | Active-low line sync for pin mode |
| frame_sync | input | 1 | Frame start marker for slot mode |
| rx_bit | input | 1 | Serial data |
| slot_offset | input | OFS_W | First window position after frame sync (captured on enable) |
| slot_width | input | OFS_W | Window length in bits (captured on enable) |
| buf_len | input | LEN_W | Buffer length in characters, 0 = 2**LEN_W |
| buf_cont | input | 1 | Continuous flag of the buffer in progress |
| synced | output | 1 | Receiver locked |
| char_valid | output | 1 | One-cycle character strobe |
| char_data | output | CHAR_W | Assembled character, bit 0 received first |
| buf_wrap | output | 1 | End of buffer, with the last character |
| buf_full | output | 1 | End of buffer that is marked filled |

## Verification
The bench locks in pin mode only after several edges with `sync_n` high. It then checks that the lock bit itself became bit 0 of the first character. A design that dropped it, or took it one edge late, would shift every character by one bit. It toggles `sync_n`, `slot_mode` and the slot settings while enabled. A design that re-armed the lock or used live settings would then lose or gain bits. It disables the receiver in the middle of a character and partway through a buffer. A design that kept the partial bits or the count would produce a corrupted first character or an early end-of-buffer. Slot runs cover a window in the middle of a longer frame, a window that starts at position 0 on the frame-sync edge itself, buffers of one character, and the continuous flag. Together these expose wrong window edges and a buffer-filled pulse that does not follow the flag.

// File: rtl/xrx_pkg.sv
`timescale 1ns/1ps
package xrx_pkg;
   typedef enum logic {
      XRX_PIN  = 1'b0,
      XRX_SLOT = 1'b1
   } xrx_mode_e;
endpackage

// File: rtl/xrx_cfg_hold.sv
`timescale 1ns/1ps
// Captures mode and slot window on the first enabled edge; live values pass
// through during that first edge so no cycle is lost.
module xrx_cfg_hold #(
   parameter int OFS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             mode_in,
   input  logic [OFS_W-1:0] off_in,
   input  logic [OFS_W-1:0] wid_in,
   output logic             mode_eff,
   output logic [OFS_W-1:0] off_eff,
   output logic [OFS_W-1:0] wid_eff
);
   logic             en_q;
   logic             mode_q;
   logic [OFS_W-1:0] off_q;
   logic [OFS_W-1:0] wid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= 1'b0;
         off_q  <= '0;
         wid_q  <= '0;
      end else begin
         en_q <= rx_en;
         if (!en_q) begin
            mode_q <= mode_in;
            off_q  <= off_in;
            wid_q  <= wid_in;
         end
      end
   end

   assign mode_eff = en_q ? mode_q : mode_in;
   assign off_eff  = en_q ? off_q  : off_in;
   assign wid_eff  = en_q ? wid_q  : wid_in;
endmodule

// File: rtl/xrx_sync_gate.sv
`timescale 1ns/1ps
// Decides on each edge whether the current bit is taken, and holds the lock.
module xrx_sync_gate #(
   parameter int OFS_W   = 8,
   parameter bit SLOT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             mode,
   input  logic [OFS_W-1:0] off,
   input  logic [OFS_W-1:0] wid,
   input  logic             sync_n,
   input  logic             frame_sync,
   output logic             take,
   output logic             synced
);
   import xrx_pkg::*;

   localparam int POS_W = OFS_W + 1;

   logic synced_q;
   logic pin_take;
   logic slot_take;

   assign pin_take = synced_q | ~sync_n;

   generate
      if (SLOT_EN) begin : g_slot
         logic [POS_W-1:0] pos_q;
         logic             seen_q;
         logic [POS_W-1:0] cur_pos;
         logic [POS_W-1:0] win_lo;
         logic [POS_W-1:0] win_hi;

         assign cur_pos   = frame_sync ? '0 : pos_q;
         assign win_lo    = {1'b0, off};
         assign win_hi    = win_lo + {1'b0, wid};
         assign slot_take = (frame_sync | seen_q) &&
                            (cur_pos >= win_lo) && (cur_pos < win_hi);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pos_q  <= '0;
               seen_q <= 1'b0;
            end else if (!rx_en) begin
               pos_q  <= '0;
               seen_q <= 1'b0;
            end else begin
               if (frame_sync) begin
                  seen_q <= 1'b1;
                  pos_q  <= POS_W'(1);
               end else if (seen_q && (pos_q != {POS_W{1'b1}})) begin
                  pos_q <= pos_q + POS_W'(1);
               end
            end
         end
      end else begin : g_noslot
         assign slot_take = 1'b0;
      end
   endgenerate

   assign take = rx_en && ((mode == XRX_SLOT) ? slot_take : pin_take);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      synced_q <= 1'b0;
      else if (!rx_en) synced_q <= 1'b0;
      else             synced_q <= synced_q | take;
   end

   assign synced = synced_q;
endmodule

// File: rtl/xrx_char_asm.sv
`timescale 1ns/1ps
// LSB-first shift assembly of taken bits into characters.
module xrx_char_asm #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              take,
   input  logic              bit_in,
   output logic              char_done,
   output logic              char_valid,
   output logic [CHAR_W-1:0] char_data
);
   localparam int CNT_W = $clog2(CHAR_W);

   logic [CHAR_W-1:0] sh_q;
   logic [CHAR_W-1:0] sh_n;
   logic [CNT_W-1:0]  cnt_q;

   assign sh_n      = {bit_in, sh_q[CHAR_W-1:1]};
   assign char_done = take && (cnt_q == CNT_W'(CHAR_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q       <= '0;
         cnt_q      <= '0;
         char_valid <= 1'b0;
         char_data  <= '0;
      end else if (!rx_en) begin
         sh_q       <= '0;
         cnt_q      <= '0;
         char_valid <= 1'b0;
      end else begin
         char_valid <= char_done;
         if (take) begin
            sh_q  <= sh_n;
            cnt_q <= char_done ? '0 : cnt_q + CNT_W'(1);
         end
         if (char_done) char_data <= sh_n;
      end
   end
endmodule

// File: rtl/xrx_buf_count.sv
`timescale 1ns/1ps
// Counts characters per buffer and raises end-of-buffer events.
module xrx_buf_count #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             char_done,
   input  logic [LEN_W-1:0] buf_len,
   input  logic             buf_cont,
   output logic             buf_wrap,
   output logic             buf_full
);
   logic [LEN_W-1:0] cnt_q;
   logic             last_c;

   assign last_c = char_done && (cnt_q == (buf_len - LEN_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         buf_wrap <= 1'b0;
         buf_full <= 1'b0;
      end else if (!rx_en) begin
         cnt_q    <= '0;
         buf_wrap <= 1'b0;
         buf_full <= 1'b0;
      end else begin
         buf_wrap <= last_c;
         buf_full <= last_c & ~buf_cont;
         if (char_done) cnt_q <= last_c ? '0 : cnt_q + LEN_W'(1);
      end
   end
endmodule

// File: rtl/sync_xparent_rx.sv
`timescale 1ns/1ps
module sync_xparent_rx #(
   parameter int CHAR_W  = 8,
   parameter int OFS_W   = 8,
   parameter int LEN_W   = 8,
   parameter bit SLOT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              slot_mode,
   input  logic              sync_n,
   input  logic              frame_sync,
   input  logic              rx_bit,
   input  logic [OFS_W-1:0]  slot_offset,
   input  logic [OFS_W-1:0]  slot_width,
   input  logic [LEN_W-1:0]  buf_len,
   input  logic              buf_cont,
   output logic              synced,
   output logic              char_valid,
   output logic [CHAR_W-1:0] char_data,
   output logic              buf_wrap,
   output logic              buf_full
);
   generate
      if (CHAR_W < 2) begin : g_bad_char
         $error("CHAR_W must be at least 2");
      end
      if (OFS_W < 1) begin : g_bad_ofs
         $error("OFS_W must be at least 1");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("LEN_W must be at least 1");
      end
   endgenerate

   logic             mode_eff;
   logic [OFS_W-1:0] off_eff;
   logic [OFS_W-1:0] wid_eff;
   logic             take;
   logic             char_done;

   xrx_cfg_hold #(.OFS_W(OFS_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
      .mode_in(slot_mode), .off_in(slot_offset), .wid_in(slot_width),
      .mode_eff(mode_eff), .off_eff(off_eff), .wid_eff(wid_eff)
   );

   xrx_sync_gate #(.OFS_W(OFS_W), .SLOT_EN(SLOT_EN)) u_gate (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
      .mode(mode_eff), .off(off_eff), .wid(wid_eff),
      .sync_n(sync_n), .frame_sync(frame_sync),
      .take(take), .synced(synced)
   );

   xrx_char_asm #(.CHAR_W(CHAR_W)) u_asm (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
      .take(take), .bit_in(rx_bit),
      .char_done(char_done), .char_valid(char_valid), .char_data(char_data)
   );

   xrx_buf_count #(.LEN_W(LEN_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
      .char_done(char_done), .buf_len(buf_len), .buf_cont(buf_cont),
      .buf_wrap(buf_wrap), .buf_full(buf_full)
   );
endmodule

// File: rtl/xrx_checker.sv
`timescale 1ns/1ps
module xrx_checker (
   input logic clk,
   input logic rst_n,
   input logic rx_en,
   input logic mode_eff,
   input logic sync_n,
   input logic synced,
   input logic char_valid,
   input logic buf_wrap,
   input logic buf_full,
   input logic buf_cont
);
   p_lock_on_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && !mode_eff && !sync_n) |=> synced);

   p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && synced) |=> synced);

   p_disable_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (!synced && !char_valid && !buf_wrap && !buf_full));

   p_mode_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_en |=> (!rx_en || $stable(mode_eff)));

   p_wrap_with_char_r8: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wrap |-> char_valid);

   p_full_needs_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full |-> buf_wrap);

   p_full_follows_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wrap |-> (buf_full == !$past(buf_cont)));
endmodule

bind sync_xparent_rx xrx_checker u_chk (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mode_eff(mode_eff),
   .sync_n(sync_n), .synced(synced), .char_valid(char_valid),
   .buf_wrap(buf_wrap), .buf_full(buf_full), .buf_cont(buf_cont)
);

// File: tb/sync_xparent_rx_tb.sv
`timescale 1ns/1ps
module sync_xparent_rx_tb;
   localparam int CW = 8;
   localparam int OW = 8;
   localparam int LW = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n, rx_en, slot_mode, sync_n, frame_sync, rx_bit, buf_cont;
   logic [OW-1:0] slot_offset, slot_width;
   logic [LW-1:0] buf_len;
   logic          synced, char_valid, buf_wrap, buf_full;
   logic [CW-1:0] char_data;

   sync_xparent_rx #(.CHAR_W(CW), .OFS_W(OW), .LEN_W(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .slot_mode(slot_mode),
      .sync_n(sync_n), .frame_sync(frame_sync), .rx_bit(rx_bit),
      .slot_offset(slot_offset), .slot_width(slot_width),
      .buf_len(buf_len), .buf_cont(buf_cont),
      .synced(synced), .char_valid(char_valid), .char_data(char_data),
      .buf_wrap(buf_wrap), .buf_full(buf_full)
   );

   typedef struct packed {
      logic [CW-1:0] d;
      logic          w;
      logic          f;
   } exp_t;

   exp_t          exp_q[$];
   int            n_cmp = 0;
   int            n_bad = 0;
   bit            done  = 1'b0;
   string         cur_tag = "R7";
   logic [CW-1:0] m_sh = '0;
   int            m_nb = 0;
   int            m_nc = 0;
   int            off_b = 0;
   int            wid_b = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // Requirement-level model: LSB-first packing and buffer accounting.
   task automatic accept_bit(input logic b);
      int lim;
      logic w;
      m_sh = {b, m_sh[CW-1:1]};
      m_nb++;
      if (m_nb == CW) begin
         m_nb = 0;
         m_nc++;
         lim = (buf_len == 0) ? (1 << LW) : int'(buf_len);
         w = (m_nc == lim);
         if (w) m_nc = 0;
         exp_q.push_back('{d: m_sh, w: w, f: w && !buf_cont});
      end
   endtask

   task automatic model_clear();
      m_sh = '0;
      m_nb = 0;
      m_nc = 0;
   endtask

   task automatic pin_bit(input logic b, input logic s_n, input logic acc);
      rx_bit = b;
      sync_n = s_n;
      if (acc) accept_bit(b);
      @(negedge clk);
   endtask

   task automatic pin_char(input logic [CW-1:0] v, input bit lock_first);
      for (int i = 0; i < CW; i++) begin
         pin_bit(v[i], (i == 0 && lock_first) ? 1'b0 : 1'(($urandom_range(0, 1))), 1'b1);
      end
   endtask

   task automatic slot_frame(input int len, input logic [31:0] pat, inout int idx,
                             input bit chk_lock);
      for (int p = 0; p < len; p++) begin
         logic acc;
         logic b;
         acc = (p >= off_b) && (p < off_b + wid_b);
         b = acc ? pat[idx] : 1'(($urandom_range(0, 1)));
         if (acc) begin
            idx++;
            accept_bit(b);
         end
         frame_sync = (p == 0);
         sync_n = 1'(($urandom_range(0, 1)));
         rx_bit = b;
         @(negedge clk);
         if (chk_lock) chk("R10 R5 lock at first window bit", 32'(synced), 32'(p >= off_b));
      end
      frame_sync = 1'b0;
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (!done && rst_n === 1'b1 && char_valid === 1'b1) begin
         if (exp_q.size() == 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL %s unexpected character actual=%0h expected=none", cur_tag, char_data);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk({cur_tag, " R7 data"}, 32'(char_data), 32'(e.d));
            chk({cur_tag, " R8 wrap"}, 32'(buf_wrap), 32'(e.w));
            chk({cur_tag, " R9 full"}, 32'(buf_full), 32'(e.f));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int idx;
      logic [31:0] pat;
      rst_n = 1'b0; rx_en = 1'b0; slot_mode = 1'b0; sync_n = 1'b1;
      frame_sync = 1'b0; rx_bit = 1'b0; slot_offset = '0; slot_width = '0;
      buf_len = 8'd3; buf_cont = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4 reset synced", 32'(synced), 0);
      chk("R4 reset char_valid", 32'(char_valid), 0);
      chk("R4 reset buf_wrap", 32'(buf_wrap), 0);

      // Pin mode: sync_n low while disabled does nothing
      cur_tag = "R1";
      sync_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 no lock while disabled", 32'(synced), 0);
      chk("R1 no character while disabled", 32'(char_valid), 0);

      rx_en = 1'b1;
      for (int i = 0; i < 4; i++) pin_bit(1'(($urandom_range(0, 1))), 1'b1, 1'b0);
      chk("R1 no lock while sync_n high", 32'(synced), 0);
      cur_tag = "R1 R2";
      pin_bit(1'b1, 1'b0, 1'b1);   // bit 0 of 0xA5 on the lock edge
      chk("R1 lock after sync_n low", 32'(synced), 1);
      for (int i = 1; i < CW; i++) pin_bit(8'hA5 >> i, 1'(($urandom_range(0, 1))), 1'b1);
      cur_tag = "R3 R6";
      slot_mode = 1'b1;            // live change must be ignored
      slot_offset = 8'd200;
      pin_char(8'h3C, 1'b0);
      pin_char(8'h0F, 1'b0);       // third char: buffer ends, marked filled
      chk("R3 lock held with sync_n toggling", 32'(synced), 1);
      cur_tag = "R9 continuous";
      buf_cont = 1'b1;
      pin_char(8'h81, 1'b0);
      pin_char(8'h7E, 1'b0);
      pin_char(8'h55, 1'b0);       // wrap without filled pulse
      buf_cont = 1'b0;

      // Disable in mid-buffer and mid-character
      cur_tag = "R4";
      buf_len = 8'd2;
      pin_char(8'h12, 1'b0);       // one of two
      for (int i = 0; i < 5; i++) pin_bit(1'b1, 1'b1, 1'b0);  // discarded
      rx_en = 1'b0;
      slot_mode = 1'b0;
      model_clear();
      @(negedge clk);
      chk("R4 disable clears lock", 32'(synced), 0);
      chk("R4 disable clears strobe", 32'(char_valid), 0);
      @(negedge clk);
      rx_en = 1'b1;
      pin_bit(1'b0, 1'b1, 1'b0);
      chk("R1 no relock without sync_n low", 32'(synced), 0);
      pin_char(8'h66, 1'b1);       // no wrap: count restarted
      pin_char(8'h99, 1'b0);       // wrap
      @(negedge clk);
      chk("R4 R8 pin-mode expected characters all seen", 32'(exp_q.size()), 0);

      // Slot mode, window 3..6 inside a 10-bit frame
      rx_en = 1'b0;
      model_clear();
      slot_mode = 1'b1; slot_offset = 8'd3; slot_width = 8'd4;
      off_b = 3; wid_b = 4;
      buf_len = 8'd2;
      @(negedge clk);
      rx_en = 1'b1;
      cur_tag = "R5";
      for (int i = 0; i < 5; i++) begin
         rx_bit = 1'(($urandom_range(0, 1)));
         sync_n = 1'b0;
         @(negedge clk);
      end
      chk("R5 no lock before frame sync", 32'(synced), 0);
      pat = 32'h0000_5AC3;
      idx = 0;
      slot_frame(10, pat, idx, 1'b1);
      cur_tag = "R5 R6";
      slot_offset = 8'd0; slot_width = 8'd8; slot_mode = 1'b0;  // ignored
      slot_frame(10, pat, idx, 1'b0);
      slot_frame(10, pat, idx, 1'b0);
      slot_frame(10, pat, idx, 1'b0);
      repeat (2) @(negedge clk);
      chk("R5 R6 slot expected characters all seen", 32'(exp_q.size()), 0);

      // Slot mode, window from the frame-sync edge, one-character buffers
      rx_en = 1'b0;
      model_clear();
      slot_mode = 1'b1; slot_offset = 8'd0; slot_width = 8'd8;
      off_b = 0; wid_b = 8;
      buf_len = 8'd1;
      @(negedge clk);
      rx_en = 1'b1;
      cur_tag = "R5 R8 offset zero";
      pat = 32'h0000_18E7;
      idx = 0;
      slot_frame(12, pat, idx, 1'b0);
      buf_cont = 1'b1;
      slot_frame(12, pat, idx, 1'b0);
      buf_cont = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 R9 all expected characters seen", 32'(exp_q.size()), 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule